// File: doc/BRIEF.md
# General-Purpose I/O Port with Atomic Latch Operations

This block is a 32-pin general-purpose I/O port. Software reaches it through a small register bus with an address, write data, a write strobe and registered read data. Each pin is assigned either to the port's own logic or to a peripheral. In port mode, a direction bit decides whether the pin drives the value held in an output latch or is left as an input. In peripheral mode, the peripheral's own drive enable and drive value reach the pad, and the peripheral receives the pin level.

The output latch has four write paths. The data register loads it directly. Three write-one-only aliases set, clear or invert single bits, so firmware can change one pin without reading the port first. A read of the data register returns the synchronized pin levels, not the latch. Because the latch can be written while a pin is still an input, the pin starts driving the chosen level on the same cycle it becomes an output.

Top module: `gpio_port`

## Requirements
- R1: After a synchronous reset every pin is in port mode, is an input and has a latch value of 0, so `pin_oe` and `pin_out` are all 0 and reads of offsets 0, 1 and 2 return 0 while the pins are low.
- R2: Offset 0 is the function register (bit n = 1 hands pin n to the peripheral, 0 keeps it in port mode). Offset 1 is the direction register (bit n = 1 drives pin n, 0 makes it an input). Both read back the last value written.
- R3: For a pin in port mode, `pin_oe` equals its direction bit and `pin_out` equals its latch bit, one clock after the register changes.
- R4: For a pin in peripheral mode, `pin_oe` and `pin_out` equal `per_oe` and `per_out` of that pin one clock later, whatever its direction and latch bits hold.
- R5: A write of a word to offset 3 sets every latch bit that has a 1 in the word and leaves the bits that have a 0 unchanged.
- R6: A write of a word to offset 4 clears every latch bit that has a 1 in the word and leaves the bits that have a 0 unchanged.
- R7: A write of a word to offset 5 inverts every latch bit that has a 1 in the word and leaves the bits that have a 0 unchanged.
- R8: A write to offset 2 loads the whole latch. A read of offset 2 returns `pin_in` after a two-stage synchronizer (read data shows a pin level three clocks after it is applied) and never the latch.
- R9: A latch value written while the pin is an input appears on `pin_out` at once, and the pin drives it in the first cycle that `pin_oe` is 1 after the direction changes.
- R10: `per_in` carries the synchronized level of each pin in peripheral mode and 0 for each pin in port mode.
- R11: Reads of offsets 3, 4, 5, 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset for writes and reads |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for the offset of the previous cycle |
| pin_in | input | 32 | Level seen at each pin |
| pin_oe | output | 32 | Drive enable for each pin |
| pin_out | output | 32 | Drive value for each pin |
| per_oe | input | 32 | Peripheral drive enable, per pin |
| per_out | input | 32 | Peripheral drive value, per pin |
| per_in | output | 32 | Pin level passed to the peripheral, per pin |

## Verification
Random mixes of writes to all six offsets run against a bench model of the function, direction and latch registers, while the peripheral signals and pin levels change each step. Random words with mixed ones and zeros written to the set, clear and toggle offsets separate the three operations from one another and from a plain load: a design that ignores the zero bits, or treats one alias as another, gives a different latch. Random function masks mix port-mode and peripheral-mode pins in one word, which shows whether routing is per pin. Directed steps cover the reset state, preloading a latch bit before the direction changes, an all-zero alias write, and reading the data offset while the latch differs from the pins.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int unsigned OFS_W = 3;

  typedef enum logic [OFS_W-1:0] {
    OFS_FUNC  = 3'd0,
    OFS_DIR   = 3'd1,
    OFS_DATA  = 3'd2,
    OFS_SET   = 3'd3,
    OFS_CLR   = 3'd4,
    OFS_TGL   = 3'd5,
    OFS_RSV6  = 3'd6,
    OFS_RSV7  = 3'd7
  } gp_ofs_e;

  typedef enum logic [2:0] {
    LOP_HOLD,
    LOP_LOAD,
    LOP_SET,
    LOP_CLR,
    LOP_TGL
  } latch_op_e;

  function automatic latch_op_e decode_op(input logic wr, input gp_ofs_e ofs);
    if (!wr) return LOP_HOLD;
    case (ofs)
      OFS_DATA: return LOP_LOAD;
      OFS_SET:  return LOP_SET;
      OFS_CLR:  return LOP_CLR;
      OFS_TGL:  return LOP_TGL;
      default:  return LOP_HOLD;
    endcase
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned PINS   = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] raw,
  output logic [PINS-1:0] synced
);
  logic [PINS-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= raw;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign synced = chain[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_port_pkg::*;
#(
  parameter int unsigned PINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OFS_W-1:0] bus_addr,
  input  logic [PINS-1:0]  bus_wdata,
  input  logic             bus_wr,
  input  logic [PINS-1:0]  pin_sync,
  output logic [PINS-1:0]  bus_rdata,
  output logic [PINS-1:0]  func_q,
  output logic [PINS-1:0]  dir_q,
  output logic [PINS-1:0]  latch_q
);
  gp_ofs_e   ofs;
  latch_op_e op;
  logic [PINS-1:0] latch_d;
  logic [PINS-1:0] rd_d;

  assign ofs = gp_ofs_e'(bus_addr);
  assign op  = decode_op(bus_wr, ofs);

  always_comb begin
    case (op)
      LOP_LOAD: latch_d = bus_wdata;
      LOP_SET:  latch_d = latch_q | bus_wdata;
      LOP_CLR:  latch_d = latch_q & ~bus_wdata;
      LOP_TGL:  latch_d = latch_q ^ bus_wdata;
      default:  latch_d = latch_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      func_q  <= '0;
      dir_q   <= '0;
      latch_q <= '0;
    end else begin
      latch_q <= latch_d;
      if (bus_wr && ofs == OFS_FUNC) func_q <= bus_wdata;
      if (bus_wr && ofs == OFS_DIR)  dir_q  <= bus_wdata;
    end
  end

  always_comb begin
    case (ofs)
      OFS_FUNC: rd_d = func_q;
      OFS_DIR:  rd_d = dir_q;
      OFS_DATA: rd_d = pin_sync;
      default:  rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_d;
  end

  // R5: every one in a set word is present in the latch afterwards
  a_r5_set_sticks: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && ofs == OFS_SET) |=> ((latch_q & $past(bus_wdata)) == $past(bus_wdata)));

  // R6: every one in a clear word is absent from the latch afterwards
  a_r6_clear_sticks: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && ofs == OFS_CLR) |=> ((latch_q & $past(bus_wdata)) == '0));

  // R7: zero bits of a toggle word keep their latch value
  a_r7_toggle_zeros_hold: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && ofs == OFS_TGL) |=> ((latch_q & ~$past(bus_wdata)) == ($past(latch_q) & ~$past(bus_wdata))));

  // R8: without a latch write the latch keeps its value
  a_r8_latch_holds: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && (ofs == OFS_DATA || ofs == OFS_SET || ofs == OFS_CLR || ofs == OFS_TGL)) |=> $stable(latch_q));

  // R11: alias and spare offsets read as zero
  a_r11_alias_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_addr > 3'd2) |=> (bus_rdata == '0));
endmodule

// File: rtl/gpio_pin_route.sv
module gpio_pin_route #(
  parameter int unsigned PINS = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] func_q,
  input  logic [PINS-1:0] dir_q,
  input  logic [PINS-1:0] latch_q,
  input  logic [PINS-1:0] pin_sync,
  input  logic [PINS-1:0] per_oe,
  input  logic [PINS-1:0] per_out,
  output logic [PINS-1:0] pin_oe,
  output logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] per_in
);
  for (genvar p = 0; p < PINS; p++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        pin_oe[p]  <= 1'b0;
        pin_out[p] <= 1'b0;
        per_in[p]  <= 1'b0;
      end else if (func_q[p]) begin
        pin_oe[p]  <= per_oe[p];
        pin_out[p] <= per_out[p];
        per_in[p]  <= pin_sync[p];
      end else begin
        pin_oe[p]  <= dir_q[p];
        pin_out[p] <= latch_q[p];
        per_in[p]  <= 1'b0;
      end
    end
  end

  // R3: port-mode pins follow direction and latch one clock later
  a_r3_port_drive: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((pin_oe ^ $past(dir_q)) | (pin_out ^ $past(latch_q))) & ~$past(func_q)) == '0);

  // R4: peripheral-mode pins follow the peripheral one clock later
  a_r4_periph_drive: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((pin_oe ^ $past(per_oe)) | (pin_out ^ $past(per_out))) & $past(func_q)) == '0);

  // R10: port-mode pins give the peripheral a zero
  a_r10_per_in_gated: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((per_in & ~$past(func_q)) == '0));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned PINS        = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OFS_W-1:0] bus_addr,
  input  logic [PINS-1:0]  bus_wdata,
  input  logic             bus_wr,
  output logic [PINS-1:0]  bus_rdata,
  input  logic [PINS-1:0]  pin_in,
  output logic [PINS-1:0]  pin_oe,
  output logic [PINS-1:0]  pin_out,
  input  logic [PINS-1:0]  per_oe,
  input  logic [PINS-1:0]  per_out,
  output logic [PINS-1:0]  per_in
);
  logic [PINS-1:0] pin_sync;
  logic [PINS-1:0] func_q;
  logic [PINS-1:0] dir_q;
  logic [PINS-1:0] latch_q;

  gpio_in_sync #(.PINS(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .raw    (pin_in),
    .synced (pin_sync)
  );

  gpio_regfile #(.PINS(PINS)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .pin_sync  (pin_sync),
    .bus_rdata (bus_rdata),
    .func_q    (func_q),
    .dir_q     (dir_q),
    .latch_q   (latch_q)
  );

  gpio_pin_route #(.PINS(PINS)) u_route (
    .clk      (clk),
    .rst      (rst),
    .func_q   (func_q),
    .dir_q    (dir_q),
    .latch_q  (latch_q),
    .pin_sync (pin_sync),
    .per_oe   (per_oe),
    .per_out  (per_out),
    .pin_oe   (pin_oe),
    .pin_out  (pin_out),
    .per_in   (per_in)
  );

  // R1: outputs stay quiet until a direction or function write
  a_r1_no_drive_without_config: assert property (@(posedge clk) disable iff (rst)
    (func_q == '0 && dir_q == '0) |=> (pin_oe == '0));
endmodule

// File: tb/gpio_port_test.sv
module gpio_port_test;
  localparam int PINS = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [2:0]      bus_addr = '0;
  logic [PINS-1:0] bus_wdata = '0;
  logic            bus_wr = 1'b0;
  logic [PINS-1:0] bus_rdata;
  logic [PINS-1:0] pin_in = '0;
  logic [PINS-1:0] pin_oe;
  logic [PINS-1:0] pin_out;
  logic [PINS-1:0] per_oe = '0;
  logic [PINS-1:0] per_out = '0;
  logic [PINS-1:0] per_in;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [PINS-1:0] m_func = '0, m_dir = '0, m_latch = '0;

  always #10 clk = ~clk;

  gpio_port uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_oe(pin_oe), .pin_out(pin_out), .per_oe(per_oe),
    .per_out(per_out), .per_in(per_in)
  );

  task automatic check(input string req, input logic [PINS-1:0] act, input logic [PINS-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [PINS-1:0] next_latch(input logic [2:0] a, input logic [PINS-1:0] w,
                                                  input logic [PINS-1:0] l);
    case (a)
      3'd2:    return w;
      3'd3:    return l | w;
      3'd4:    return l & ~w;
      3'd5:    return l ^ w;
      default: return l;
    endcase
  endfunction

  function automatic logic [PINS-1:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0:    return m_func;
      3'd1:    return m_dir;
      3'd2:    return pin_in;
      default: return '0;
    endcase
  endfunction

  // write at a negedge, then two edges: registers, then registered outputs
  task automatic write_reg(input logic [2:0] a, input logic [PINS-1:0] w);
    bus_addr = a; bus_wdata = w; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == 3'd0) m_func = w;
    if (a == 3'd1) m_dir = w;
    m_latch = next_latch(a, w, m_latch);
    @(negedge clk);
  endtask

  task automatic check_pins(input string tag);
    check({tag, " pin_oe"}, pin_oe, (m_func & per_oe) | (~m_func & m_dir));
    check({tag, " pin_out"}, pin_out, (m_func & per_out) | (~m_func & m_latch));
  endtask

  task automatic read_check(input string req, input logic [2:0] a);
    logic [PINS-1:0] e;
    bus_addr = a;
    e = exp_read(a);
    @(negedge clk);
    check(req, bus_rdata, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check("R1 pin_oe", pin_oe, '0);
    check("R1 pin_out", pin_out, '0);
    check("R1 per_in", per_in, '0);
    read_check("R1 func read", 3'd0);
    read_check("R1 dir read", 3'd1);
    read_check("R1 data read", 3'd2);

    // R9: preload latch while input, then turn to output
    write_reg(3'd3, 32'h0000_0005);
    check("R9 still input", pin_oe, '0);
    check("R9 preload visible", pin_out, 32'h0000_0005);
    write_reg(3'd1, 32'h0000_0007);
    check("R9 drives preload", pin_oe & pin_out, 32'h0000_0005);
    check_pins("R3 after dir");

    // R5 R6 R7: all-zero alias writes change nothing
    write_reg(3'd3, '0);
    check("R5 zero set", pin_out, 32'h0000_0005);
    write_reg(3'd4, '0);
    check("R6 zero clear", pin_out, 32'h0000_0005);
    write_reg(3'd5, '0);
    check("R7 zero toggle", pin_out, 32'h0000_0005);
    write_reg(3'd5, 32'h0000_000f);
    check("R7 toggle", pin_out, 32'h0000_000a);
    write_reg(3'd4, 32'h0000_0008);
    check("R6 clear", pin_out, 32'h0000_0002);

    // R8: data read returns pins, not latch
    write_reg(3'd2, 32'hffff_0000);
    pin_in = 32'h0000_ffff;
    repeat (3) @(negedge clk);
    read_check("R8 data read is pins", 3'd2);
    check("R8 load", pin_out, 32'hffff_0000);

    // R4 R10: whole port to peripheral
    per_oe = 32'h1234_5678; per_out = 32'h8765_4321;
    write_reg(3'd0, '1);
    check_pins("R4 all periph");
    @(negedge clk);
    check("R10 per_in periph", per_in, pin_in);
    read_check("R2 func read", 3'd0);
    read_check("R11 tgl read", 3'd5);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [2:0] a, ra;
      a = 3'($urandom_range(0, 5));
      per_oe  = $urandom();
      per_out = $urandom();
      pin_in  = $urandom();
      bus_addr = a; bus_wdata = $urandom(); bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      if (a == 3'd0) m_func = bus_wdata;
      if (a == 3'd1) m_dir = bus_wdata;
      m_latch = next_latch(a, bus_wdata, m_latch);
      @(negedge clk);
      check_pins("R3 R4 R5 R6 R7 random");
      ra = 3'($urandom_range(0, 7));
      if (ra == 3'd2)      read_check("R8 random read", ra);
      else if (ra <= 3'd1) read_check("R2 random read", ra);
      else                 read_check("R11 random read", ra);
      check("R10 random per_in", per_in, pin_in & m_func);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule